// File: doc/BRIEF.md
# DRAM Open-Row Access Policy Controller

This block decides what the row strobe of a DRAM/SDRAM controller does from one access to the next. Each incoming request carries a target area, a row address, the kind of bus master that issued it, and a read/write flag. The area is the DRAM area, another external area, or an on-chip register. The block answers each request with a short burst of memory commands, one per cycle: activate, read, write or precharge. It also reports whether the data command runs in fast-page mode, which leaves the row open, or in full access mode, which closes the row afterwards.

Three configuration bits steer the policy. A burst-enable bit allows rows to stay open between DRAM accesses. A row-hold bit keeps the open row, with the row strobe held low, across intervening accesses to other areas. A fast-page option bit lets DMA single-address transfers use fast-page mode. The block records the open row in a held-row register with a valid flag. The row strobe output is the inverse of that flag. If burst enable is cleared while a row is held, the block releases the row on its own.

Top module: `rowpol_ctrl`

## Requirements
- R1: After reset, `ready` is 1, `ras_n` is 1 (no row held) and `cmd_valid` is 0.
- R2: A DRAM-area request (`req_area`=0) with no row held issues ACTIVATE (`cmd_code`=0) and then READ (1) or WRITE (2), one command per cycle, starting the cycle after acceptance. The row strobe is low (`ras_n`=0) during the data command.
- R3: A DRAM-area request to the held row that qualifies for fast-page mode issues only READ/WRITE, with `acc_mode`=1 (fast-page), and the row stays held.
- R4: A DRAM-area request to a different row while a row is held issues PRECHARGE (`cmd_code`=3), then ACTIVATE, then READ/WRITE. ACTIVATE is only ever issued while no row is held.
- R5: With burst enable and row-hold both set, a request to another external area (`req_area`=1) or an on-chip register (`req_area`=2) issues no command, and `ras_n` stays 0.
- R6: With row-hold cleared, a non-DRAM request while a row is held issues one PRECHARGE, and `ras_n` goes to 1 after it. Every PRECHARGE is followed by `ras_n`=1.
- R7: With burst enable cleared, row-hold has no effect. Every DRAM access is full mode (ACTIVATE, data command, PRECHARGE), and a later non-DRAM access issues nothing with `ras_n`=1.
- R8: Clearing burst enable while a row is held makes the block, once idle, issue PRECHARGE in the next cycle with `ready` low, after which `ras_n`=1.
- R9: A DMA single-address request (`req_master`=1) with the fast-page option cleared runs in full mode (`acc_mode`=0): a PRECHARGE always follows its data command, even when it targets the held row.
- R10: A DMA single-address request with burst enable and the fast-page option set runs in fast-page mode. It reuses the held row without ACTIVATE.
- R11: With burst enable cleared, a DMA single-address request is full mode even when the fast-page option is set.
- R12: The fast-page option bit does not change requests from the CPU (`req_master`=0) or DMA dual-address transfers (`req_master`=2), which run in fast-page mode whenever burst enable is set.
- R13: `cmd_valid` is a one-cycle strobe per command. `ready` is 0 in every cycle that carries a command, so no request is accepted mid-sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_burst_en | input | 1 | Allows rows to stay open between accesses |
| cfg_hold_row | input | 1 | Keeps the open row across non-DRAM accesses |
| cfg_dma_fp | input | 1 | Allows fast-page mode for DMA single-address transfers |
| req_valid | input | 1 | Request present |
| req_area | input | 2 | 0 DRAM, 1 other external, 2 on-chip register, 3 other external |
| req_row | input | ROW_W | Row address of the request |
| req_master | input | 2 | 0 CPU, 1 DMA single-address, 2 DMA dual-address, 3 other master |
| req_write | input | 1 | 1 write, 0 read |
| ready | output | 1 | Request is accepted on a clock edge where `req_valid` and `ready` are both 1 |
| cmd_valid | output | 1 | One-cycle command strobe |
| cmd_code | output | 2 | 0 ACTIVATE, 1 READ, 2 WRITE, 3 PRECHARGE |
| cmd_row | output | ROW_W | Row the command applies to |
| acc_mode | output | 1 | Mode of the current request: 1 fast-page, 0 full |
| ras_n | output | 1 | Row strobe level, low while a row is held |

## Verification
The bound checker watches the row-strobe invariants on every cycle. ACTIVATE only happens with the row strobe high, and data commands only happen with it low. A PRECHARGE always raises the strobe. A full-mode data command is always followed by PRECHARGE, and a fast-page data command leaves the row open. A held row left idle with burst enable cleared is released at once, and `ready` never coincides with a command. Which command sequence each combination of area, master, row and configuration produces can only be shown by the bench's directed scenarios. The same holds for whether an access with the same row skips ACTIVATE, and for whether the fast-page option leaves CPU and dual-address transfers unaffected.

// File: rtl/rowpol_pkg.sv
package rowpol_pkg;

  typedef enum logic [1:0] {
    AREA_DRAM = 2'd0,
    AREA_EXT  = 2'd1,
    AREA_REG  = 2'd2,
    AREA_EXTB = 2'd3
  } area_e;

  typedef enum logic [1:0] {
    MST_CPU      = 2'd0,
    MST_DMA_SGL  = 2'd1,
    MST_DMA_DUAL = 2'd2,
    MST_OTHER    = 2'd3
  } master_e;

  typedef enum logic [1:0] {
    CMD_ACT = 2'd0,
    CMD_RD  = 2'd1,
    CMD_WR  = 2'd2,
    CMD_PRE = 2'd3
  } cmd_e;

  typedef enum logic [2:0] {
    ST_IDLE      = 3'd0,
    ST_PRE_OPEN  = 3'd1,
    ST_ACT       = 3'd2,
    ST_RW        = 3'd3,
    ST_PRE_CLOSE = 3'd4
  } st_e;

  // Fast-page eligibility: burst must be on; single-address DMA also needs its option bit.
  function automatic logic fast_ok(input logic burst, input logic dma_fp,
                                   input logic [1:0] master);
    return burst && !((master == MST_DMA_SGL) && !dma_fp);
  endfunction

  // Row survives a non-DRAM access only with burst and hold both set.
  function automatic logic keep_on_suspend(input logic burst, input logic hold);
    return burst && hold;
  endfunction

endpackage

// File: rtl/rowpol_plan.sv
module rowpol_plan
  import rowpol_pkg::*;
#(
  parameter int ROW_W = 13
) (
  input  logic [1:0]       area,
  input  logic [ROW_W-1:0] row,
  input  logic [1:0]       master,
  input  logic             burst_en,
  input  logic             hold_row,
  input  logic             dma_fp,
  input  logic             held_valid,
  input  logic [ROW_W-1:0] held_row,
  output st_e              first_st,
  output logic             close_after,
  output logic             fast
);

  logic is_dram;
  logic row_hit;
  logic reuse;

  always_comb begin
    is_dram     = (area == AREA_DRAM);
    row_hit     = held_valid && (row == held_row);
    fast        = fast_ok(burst_en, dma_fp, master);
    reuse       = row_hit && fast;
    close_after = is_dram && !fast;
    if (is_dram) begin
      if (held_valid && !reuse) first_st = ST_PRE_OPEN;
      else if (!reuse)          first_st = ST_ACT;
      else                      first_st = ST_RW;
    end else begin
      if (held_valid && !keep_on_suspend(burst_en, hold_row)) first_st = ST_PRE_CLOSE;
      else                                                    first_st = ST_IDLE;
    end
  end

endmodule

// File: rtl/rowpol_rowreg.sv
module rowpol_rowreg #(
  parameter int ROW_W = 13
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             open_en,
  input  logic [ROW_W-1:0] open_row,
  input  logic             release_en,
  output logic             held_valid,
  output logic [ROW_W-1:0] held_row
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      held_valid <= 1'b0;
      held_row   <= '0;
    end else if (open_en) begin
      held_valid <= 1'b1;
      held_row   <= open_row;
    end else if (release_en) begin
      held_valid <= 1'b0;
    end
  end

endmodule

// File: rtl/rowpol_seq.sv
module rowpol_seq
  import rowpol_pkg::*;
#(
  parameter int ROW_W = 13
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic             req_write,
  input  logic [ROW_W-1:0] req_row,
  input  st_e              plan_first,
  input  logic             plan_close,
  input  logic             plan_fast,
  input  logic             auto_release,
  input  logic [ROW_W-1:0] held_row,
  output logic             ready,
  output logic             cmd_valid,
  output logic [1:0]       cmd_code,
  output logic [ROW_W-1:0] cmd_row,
  output logic             acc_mode,
  output logic             open_en,
  output logic             release_en
);

  st_e              st;
  logic             l_wr;
  logic             l_close;
  logic             l_fast;
  logic [ROW_W-1:0] l_row;
  logic             accept;

  assign ready  = (st == ST_IDLE) && !auto_release;
  assign accept = req_valid && ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= ST_IDLE;
      l_wr    <= 1'b0;
      l_close <= 1'b0;
      l_fast  <= 1'b0;
      l_row   <= '0;
    end else begin
      case (st)
        ST_IDLE: begin
          if (auto_release) begin
            st <= ST_PRE_CLOSE;
          end else if (accept) begin
            st      <= plan_first;
            l_wr    <= req_write;
            l_close <= plan_close;
            l_fast  <= plan_fast;
            l_row   <= req_row;
          end
        end
        ST_PRE_OPEN:  st <= ST_ACT;
        ST_ACT:       st <= ST_RW;
        ST_RW:        st <= l_close ? ST_PRE_CLOSE : ST_IDLE;
        ST_PRE_CLOSE: st <= ST_IDLE;
        default:      st <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    cmd_valid  = (st != ST_IDLE);
    open_en    = (st == ST_ACT);
    release_en = (st == ST_PRE_OPEN) || (st == ST_PRE_CLOSE);
    acc_mode   = l_fast;
    cmd_row    = release_en ? held_row : l_row;
    case (st)
      ST_ACT:  cmd_code = CMD_ACT;
      ST_RW:   cmd_code = l_wr ? CMD_WR : CMD_RD;
      default: cmd_code = CMD_PRE;
    endcase
  end

endmodule

// File: rtl/rowpol_ctrl.sv
module rowpol_ctrl
  import rowpol_pkg::*;
#(
  parameter int ROW_W = 13
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_burst_en,
  input  logic             cfg_hold_row,
  input  logic             cfg_dma_fp,
  input  logic             req_valid,
  input  logic [1:0]       req_area,
  input  logic [ROW_W-1:0] req_row,
  input  logic [1:0]       req_master,
  input  logic             req_write,
  output logic             ready,
  output logic             cmd_valid,
  output logic [1:0]       cmd_code,
  output logic [ROW_W-1:0] cmd_row,
  output logic             acc_mode,
  output logic             ras_n
);

  st_e              plan_first;
  logic             plan_close;
  logic             plan_fast;
  logic             held_valid;
  logic [ROW_W-1:0] held_row;
  logic             evt_open;
  logic             evt_release;
  logic             evt_auto_release;

  assign evt_auto_release = held_valid && !cfg_burst_en;
  assign ras_n            = !held_valid;

  rowpol_plan #(.ROW_W(ROW_W)) u_plan (
    .area        (req_area),
    .row         (req_row),
    .master      (req_master),
    .burst_en    (cfg_burst_en),
    .hold_row    (cfg_hold_row),
    .dma_fp      (cfg_dma_fp),
    .held_valid  (held_valid),
    .held_row    (held_row),
    .first_st    (plan_first),
    .close_after (plan_close),
    .fast        (plan_fast)
  );

  rowpol_seq #(.ROW_W(ROW_W)) u_seq (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_valid    (req_valid),
    .req_write    (req_write),
    .req_row      (req_row),
    .plan_first   (plan_first),
    .plan_close   (plan_close),
    .plan_fast    (plan_fast),
    .auto_release (evt_auto_release),
    .held_row     (held_row),
    .ready        (ready),
    .cmd_valid    (cmd_valid),
    .cmd_code     (cmd_code),
    .cmd_row      (cmd_row),
    .acc_mode     (acc_mode),
    .open_en      (evt_open),
    .release_en   (evt_release)
  );

  rowpol_rowreg #(.ROW_W(ROW_W)) u_rowreg (
    .clk        (clk),
    .rst_n      (rst_n),
    .open_en    (evt_open),
    .open_row   (cmd_row),
    .release_en (evt_release),
    .held_valid (held_valid),
    .held_row   (held_row)
  );

endmodule

// File: rtl/rowpol_chk.sv
module rowpol_chk
  import rowpol_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       cfg_burst_en,
  input logic       ready,
  input logic       cmd_valid,
  input logic [1:0] cmd_code,
  input logic       acc_mode,
  input logic       ras_n
);

  logic is_rw;
  assign is_rw = cmd_valid && ((cmd_code == CMD_RD) || (cmd_code == CMD_WR));

  AST_ACT_ROW_CLOSED: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_code == CMD_ACT) |-> ras_n);  // R4
  AST_RW_ROW_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
    is_rw |-> !ras_n);  // R2
  AST_FAST_KEEPS_ROW: assert property (@(posedge clk) disable iff (!rst_n)
    (is_rw && acc_mode) |=> !ras_n);  // R3
  AST_PRE_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_code == CMD_PRE) |=> ras_n);  // R6
  AST_FULL_CLOSES: assert property (@(posedge clk) disable iff (!rst_n)
    (is_rw && !acc_mode) |=> (cmd_valid && cmd_code == CMD_PRE));  // R9
  AST_BURST_OFF_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_burst_en && !ras_n && !cmd_valid) |=> (cmd_valid && cmd_code == CMD_PRE));  // R8
  AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> !ready);  // R13

endmodule

bind rowpol_ctrl rowpol_chk u_chk (.*);

// File: tb/tb_rowpol_ctrl.sv
module tb_rowpol_ctrl;

  localparam int RW = 13;
  localparam logic [1:0] C_ACT = 2'd0, C_RD = 2'd1, C_WR = 2'd2, C_PRE = 2'd3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cfg_burst_en = 1'b0, cfg_hold_row = 1'b0, cfg_dma_fp = 1'b0;
  logic          req_valid = 1'b0;
  logic [1:0]    req_area = 2'd0;
  logic [RW-1:0] req_row = '0;
  logic [1:0]    req_master = 2'd0;
  logic          req_write = 1'b0;
  logic          ready, cmd_valid, acc_mode, ras_n;
  logic [1:0]    cmd_code;
  logic [RW-1:0] cmd_row;

  int n_chk = 0;
  int n_bad = 0;
  logic [15:0] tr;
  logic        tr_mode;

  always #4 clk = ~clk;

  rowpol_ctrl #(.ROW_W(RW)) dut (.*);

  function automatic logic [15:0] push(input logic [15:0] t, input logic [1:0] c);
    return {t[12:0], 1'b1, c};
  endfunction

  task automatic chk(input logic ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Issue one request and capture the command trace that follows it.
  task automatic run_req(input logic [1:0] area, input logic [RW-1:0] row,
                         input logic [1:0] mst, input logic wr);
    logic busy_ok;
    @(negedge clk);
    while (!ready) @(negedge clk);
    req_valid = 1'b1; req_area = area; req_row = row; req_master = mst; req_write = wr;
    @(negedge clk);
    req_valid = 1'b0;
    tr = '0; tr_mode = 1'b0; busy_ok = 1'b1;
    for (int k = 0; k < 6; k++) begin
      if (cmd_valid) begin
        tr = push(tr, cmd_code);
        if (cmd_code == C_RD || cmd_code == C_WR) tr_mode = acc_mode;
        if (ready) busy_ok = 1'b0;
      end
      @(negedge clk);
    end
    chk(busy_ok, "R13 ready low during commands", int'(busy_ok), 1);
  endtask

  task automatic t_reset();
    chk(ready == 1'b1, "R1 ready", int'(ready), 1);
    chk(ras_n == 1'b1, "R1 ras_n", int'(ras_n), 1);
    chk(cmd_valid == 1'b0, "R1 cmd_valid", int'(cmd_valid), 0);
  endtask

  task automatic t_open_and_hit();
    cfg_burst_en = 1; cfg_hold_row = 1; cfg_dma_fp = 0;
    run_req(2'd0, 13'd5, 2'd0, 1'b0);
    chk(tr == push(push(0, C_ACT), C_RD), "R2 first access ACT,RD", tr, push(push(0, C_ACT), C_RD));
    chk(ras_n == 0, "R2 row held", int'(ras_n), 0);
    run_req(2'd0, 13'd5, 2'd0, 1'b1);
    chk(tr == push(0, C_WR), "R3 same row WR only", tr, push(0, C_WR));
    chk(tr_mode == 1, "R3 fast mode", int'(tr_mode), 1);
  endtask

  task automatic t_suspend_hold();
    run_req(2'd1, 13'd77, 2'd0, 1'b0);
    chk(tr == 0, "R5 ext area no cmd", tr, 0);
    chk(ras_n == 0, "R5 ras held ext", int'(ras_n), 0);
    run_req(2'd2, 13'd0, 2'd0, 1'b1);
    chk(tr == 0, "R5 reg area no cmd", tr, 0);
    chk(ras_n == 0, "R5 ras held reg", int'(ras_n), 0);
  endtask

  task automatic t_row_miss();
    logic [15:0] e;
    e = push(push(push(0, C_PRE), C_ACT), C_RD);
    run_req(2'd0, 13'd9, 2'd0, 1'b0);
    chk(tr == e, "R4 miss PRE,ACT,RD", tr, e);
  endtask

  task automatic t_dma_single_full();
    logic [15:0] e;
    e = push(push(push(push(0, C_PRE), C_ACT), C_RD), C_PRE);
    run_req(2'd0, 13'd9, 2'd1, 1'b0);
    chk(tr == e, "R9 dma single same row full", tr, e);
    chk(tr_mode == 0, "R9 full mode", int'(tr_mode), 0);
    chk(ras_n == 1, "R9 row closed", int'(ras_n), 1);
  endtask

  task automatic t_dma_single_fast();
    cfg_dma_fp = 1;
    run_req(2'd0, 13'd9, 2'd1, 1'b0);
    chk(tr == push(push(0, C_ACT), C_RD), "R10 open ACT,RD", tr, push(push(0, C_ACT), C_RD));
    run_req(2'd0, 13'd9, 2'd1, 1'b1);
    chk(tr == push(0, C_WR), "R10 reuse WR", tr, push(0, C_WR));
    chk(tr_mode == 1, "R10 fast mode", int'(tr_mode), 1);
  endtask

  task automatic t_fp_other_masters();
    cfg_dma_fp = 0;
    run_req(2'd0, 13'd9, 2'd2, 1'b0);
    chk(tr == push(0, C_RD), "R12 dual fast RD", tr, push(0, C_RD));
    chk(tr_mode == 1, "R12 dual fast mode", int'(tr_mode), 1);
    run_req(2'd0, 13'd9, 2'd0, 1'b1);
    chk(tr == push(0, C_WR) && tr_mode == 1, "R12 cpu fast WR", tr, push(0, C_WR));
  endtask

  task automatic t_no_hold();
    cfg_hold_row = 0;
    run_req(2'd1, 13'd1, 2'd0, 1'b0);
    chk(tr == push(0, C_PRE), "R6 release PRE", tr, push(0, C_PRE));
    chk(ras_n == 1, "R6 ras high", int'(ras_n), 1);
  endtask

  task automatic t_burst_clear();
    cfg_hold_row = 1;
    run_req(2'd0, 13'd3, 2'd0, 1'b0);
    chk(tr == push(push(0, C_ACT), C_RD) && ras_n == 0, "R8 setup open", tr, push(push(0, C_ACT), C_RD));
    cfg_burst_en = 0;
    #0;
    chk(ready == 0, "R8 ready low on clear", int'(ready), 0);
    @(negedge clk);
    chk(cmd_valid && cmd_code == C_PRE, "R8 PRE issued", int'(cmd_code), int'(C_PRE));
    chk(ready == 0, "R8 ready low during PRE", int'(ready), 0);
    @(negedge clk);
    chk(ras_n == 1 && ready == 1, "R8 released", int'(ras_n), 1);
  endtask

  task automatic t_burst_off();
    logic [15:0] e;
    e = push(push(push(0, C_ACT), C_RD), C_PRE);
    run_req(2'd0, 13'd3, 2'd0, 1'b0);
    chk(tr == e && tr_mode == 0, "R7 full with hold set", tr, e);
    run_req(2'd1, 13'd3, 2'd0, 1'b0);
    chk(tr == 0 && ras_n == 1, "R7 ext no cmd", tr, 0);
    cfg_dma_fp = 1;
    run_req(2'd0, 13'd4, 2'd1, 1'b1);
    e = push(push(push(0, C_ACT), C_WR), C_PRE);
    chk(tr == e && tr_mode == 0, "R11 dma single full with burst off", tr, e);
  endtask

  initial begin
    #(8 * 100000);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_open_and_hit();
    t_suspend_hold();
    t_row_miss();
    t_dma_single_full();
    t_dma_single_fast();
    t_fp_other_masters();
    t_no_hold();
    t_burst_clear();
    t_burst_off();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule